// File: doc/BRIEF.md
# Graded-Segment Conditional-Sum Select Adder

This block adds two unsigned operands of `WIDTH` bits plus a one-bit carry-in and registers the sum and the carry-out on the next rising clock edge. The operand word is cut into segments. Each segment after the first holds two ripple chains that work at the same time. One chain assumes that no carry enters the segment. The other assumes that a carry enters it. When the true carry arrives from the segment below, a multiplexer picks one sum slice and one carry. That carry then drives the select of the next segment, so the serial path holds one multiplexer per segment.

The lowest segment takes the real carry-in directly and has only one chain. The per-bit propagate (`a ^ b`) and generate (`a & b`) terms are formed once and feed both chains of a segment. Only the logic that depends on the carry is built twice.

`GROW` chooses how the segments are laid out. With `GROW` = 1, each segment is one bit longer than the one below it, starting at `FIRST_LEN`. Its local add is then ready as the select carry reaches it, so the delay grows with the square root of the width. With `GROW` = 0, every segment is `FIRST_LEN` bits long. In both layouts the top segment is cut short so that the segments fill exactly `WIDTH` bits.

Top module: `csel_adder_top`

## Requirements
- R1: One clock edge after `a`, `b` and `cin` are presented, `sum_q` equals the low `WIDTH` bits of `a + b + cin`.
- R2: One clock edge after the operands are presented, `cout_q` equals bit `WIDTH` (the carry out of the most significant bit) of the full sum `a + b + cin`.
- R3: While `rst` is high at a rising edge, both `sum_q` and `cout_q` are cleared to 0 on that edge (synchronous, active-high reset).
- R4: When every bit position propagates (`a ^ b` is all ones), `cout_q` equals the `cin` that was presented, and `sum_q` is all ones if `cin` = 0 or all zeros if `cin` = 1.
- R5: With `GROW` = 1, segment k covers `FIRST_LEN + k` bits and the top segment is truncated. For a width of 32 and a first length of 4, the segment bases are bits 0, 4, 9, 15, 22 and 30. A carry produced below any base is summed correctly into the bits above it.
- R6: With `GROW` = 0, every segment is `FIRST_LEN` bits (for a width of 32, eight segments of 4 bits with bases at multiples of 4), and the results are the same as in R1 and R2.
- R7: Inside each dual-chain segment, the {carry, sum} result of the chain that assumes a carry-in of 1 is exactly one more than the result of the chain that assumes a carry-in of 0.
- R8: Inside each dual-chain segment, a carry-out from the chain that assumes a carry-in of 0 implies a carry-out from the chain that assumes a carry-in of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in to the least significant bit |
| sum_q | output | WIDTH | Registered sum, modulo 2^WIDTH |
| cout_q | output | 1 | Registered carry out of the most significant bit |

## Verification
The clocked properties assume that `a`, `b` and `cin` settle before each rising edge and hold no X or Z values outside reset. The immediate checks inside the segments skip any evaluation in which a propagate or generate bit is still unknown. The stimulus drives every input on the falling edge and loads all inputs with zeros from time zero, so each sampled value is a defined operand. The directed operands put a carry at each segment base in both layouts and force full propagation with both carry-in values. A seeded sweep of random operands then covers the mixed cases in between.

// File: rtl/csel_pkg.sv
package csel_pkg;

  function automatic int seg_raw_len(int k, int first, int grow);
    return (grow != 0) ? first + k : first;
  endfunction

  function automatic int seg_base(int k, int first, int grow);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += seg_raw_len(i, first, grow);
    return s;
  endfunction

  function automatic int seg_count(int width, int first, int grow);
    int s;
    int n;
    s = 0;
    n = 0;
    for (int i = 0; i < width; i++) begin
      if (s < width) begin
        s += seg_raw_len(n, first, grow);
        n++;
      end
    end
    return n;
  endfunction

  function automatic int seg_len(int k, int width, int first, int grow);
    int raw;
    int room;
    raw  = seg_raw_len(k, first, grow);
    room = width - seg_base(k, first, grow);
    return (raw < room) ? raw : room;
  endfunction

endpackage

// File: rtl/pg_cells.sv
module pg_cells #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);
  assign prop = x ^ y;
  assign gen  = x & y;
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int L = 4
) (
  input  logic [L-1:0] prop,
  input  logic [L-1:0] gen,
  input  logic         ci,
  output logic [L-1:0] s,
  output logic         co
);
  logic [L:0] cv;

  always_comb begin
    cv[0] = ci;
    for (int i = 0; i < L; i++) begin
      s[i]    = prop[i] ^ cv[i];
      cv[i+1] = gen[i] | (prop[i] & cv[i]);
    end
    co = cv[L];
  end
endmodule

// File: rtl/csel_segment.sv
module csel_segment #(
  parameter int L      = 4,
  parameter bit DIRECT = 1'b0
) (
  input  logic [L-1:0] prop,
  input  logic [L-1:0] gen,
  input  logic         sel_c,
  output logic [L-1:0] s,
  output logic         co
);
  generate
    if (DIRECT) begin : g_single
      ripple_chain #(.L(L)) u_chain (
        .prop(prop), .gen(gen), .ci(sel_c), .s(s), .co(co)
      );
    end else begin : g_dual
      logic [L-1:0] s_lo, s_hi;
      logic         co_lo, co_hi;

      ripple_chain #(.L(L)) u_lo (
        .prop(prop), .gen(gen), .ci(1'b0), .s(s_lo), .co(co_lo)
      );
      ripple_chain #(.L(L)) u_hi (
        .prop(prop), .gen(gen), .ci(1'b1), .s(s_hi), .co(co_hi)
      );

      assign s  = sel_c ? s_hi  : s_lo;
      assign co = sel_c ? co_hi : co_lo;

      always_comb begin
        if (!$isunknown({prop, gen})) begin
          a_r7_pair_step: assert ({co_hi, s_hi} == ({co_lo, s_lo} + (L+1)'(1)))
            else $error("R7: carry-in-one chain is not one above carry-in-zero chain");
          a_r8_carry_order: assert (!co_lo || co_hi)
            else $error("R8: carry from zero chain without carry from one chain");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/csel_adder_top.sv
module csel_adder_top #(
  parameter int WIDTH     = 32,
  parameter int FIRST_LEN = 4,
  parameter int GROW      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);
  import csel_pkg::*;

  localparam int NSEG = seg_count(WIDTH, FIRST_LEN, GROW);

  logic [WIDTH-1:0] prop, gen, sum_c;
  logic [NSEG:0]    carry;

  pg_cells #(.W(WIDTH)) u_pg (.x(a), .y(b), .prop(prop), .gen(gen));

  assign carry[0] = cin;

  generate
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      localparam int BASE = seg_base(k, FIRST_LEN, GROW);
      localparam int LEN  = seg_len(k, WIDTH, FIRST_LEN, GROW);
      csel_segment #(.L(LEN), .DIRECT(k == 0)) u_seg (
        .prop (prop[BASE +: LEN]),
        .gen  (gen[BASE +: LEN]),
        .sel_c(carry[k]),
        .s    (sum_c[BASE +: LEN]),
        .co   (carry[k+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      cout_q <= carry[NSEG];
    end
  end

  a_r1_r2_sum_match: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_q, sum_q} == $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})))
    else $error("R1/R2: registered result differs from arithmetic sum");

  a_r3_reset_clear: assert property (@(posedge clk)
    rst |=> (sum_q == '0) && !cout_q)
    else $error("R3: outputs not cleared by reset");

  a_r4_full_propagate: assert property (@(posedge clk) disable iff (rst)
    (&(a ^ b)) |=> (cout_q == $past(cin)))
    else $error("R4: carry-in did not pass through a full-propagate word");

  a_r2_top_generate: assert property (@(posedge clk) disable iff (rst)
    (a[WIDTH-1] && b[WIDTH-1]) |=> cout_q)
    else $error("R2: top-bit generate did not give a carry-out");
endmodule

// File: tb/sim_csel_adder_top.sv
module sim_csel_adder_top;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] sum;
    logic         cout;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum0, sum1;
  logic         cout0, cout1;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  csel_adder_top #(.WIDTH(W), .FIRST_LEN(4), .GROW(1)) u0 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum_q(sum0), .cout_q(cout0)
  );
  csel_adder_top #(.WIDTH(W), .FIRST_LEN(4), .GROW(0)) u1 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum_q(sum1), .cout_q(cout1)
  );

  task automatic compare(string tag, logic [W:0] act, logic [W:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic c, string tag);
    exp_t e;
    logic [W:0] full;
    @(negedge clk);
    a   = x;
    b   = y;
    cin = c;
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    e.sum  = full[W-1:0];
    e.cout = full[W];
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic reset_pulse();
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    a = '1; b = '1; cin = 1'b1;
    e.sum = '0; e.cout = 1'b0; e.tag = "R3 mid-run reset";
    sb.push_back(e);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: each expected item was pushed in the half cycle before this edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare({e.tag, " grow"},  {cout0, sum0}, {e.cout, e.sum});
      compare({e.tag, " fixed R6"}, {cout1, sum1}, {e.cout, e.sum});
    end
  end

  initial begin
    int grow_base[5];
    grow_base = '{4, 9, 15, 22, 30};
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R3 reset state grow",  {cout0, sum0}, '0);
    compare("R3 reset state fixed", {cout1, sum1}, '0);
    rst = 1'b0;

    drive('0, '0, 1'b0, "R1 zero");
    drive(32'h0000_0005, 32'h0000_0007, 1'b1, "R1 small");
    drive('1, 32'h1, 1'b0, "R2 wrap carry-out");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 top generate");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R4 propagate cin=1");
    drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R4 propagate cin=0");
    drive('1, '0, 1'b1, "R4 all-ones plus cin");
    for (int i = 0; i < 5; i++) begin
      drive((32'h1 << grow_base[i]) - 1, 32'h1, 1'b0, "R5 carry into grow base");
      drive((32'h1 << grow_base[i]) - 1, '0, 1'b1, "R5 cin ripple to grow base");
    end
    for (int i = 1; i < 8; i++)
      drive((32'h1 << (4*i)) - 1, 32'h1, 1'b0, "R6 carry into fixed base");
    reset_pulse();
    // R7, R8 are also checked in every segment on each vector below
    for (int i = 0; i < 300; i++)
      drive($urandom(), $urandom(), 1'($urandom()), "R1 R2 random");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule